// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on every clock cycle in which the tick-enable input is high. The tick-enable input is produced outside the block. Four match registers are compared against the counter. When a tick moves the counter onto a channel's match value and that channel is enabled for interrupts, a sticky status bit is latched. The channel's interrupt output follows that bit. Software clears a status bit by writing a one to its position in the status register.

Channel 3 also serves as a one-shot watchdog. If its match occurs while the watchdog arm bit is set, the block emits a single-cycle reset request and disarms itself. The block is reached through a simple register port. The port has a select, a write strobe, a byte address and 32-bit write data. Read data and an error flag appear one cycle after the access.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, all interrupt outputs, the error flag and the reset request are low. A read returns its data on `bus_rdata` in the cycle after the request. That data is the register value as it stood in the request cycle.
- R2: Register offsets are: match 0..3 at 0x00, 0x04, 0x08, 0x0C; counter at 0x10; status at 0x14; watchdog arm at 0x18; interrupt enable at 0x1C. Match registers read back the full value written. Interrupt enable keeps bits 3:0 and watchdog arm keeps bit 0; all other bits of these two read zero.
- R3: The counter increases by one in each cycle with `tick_en` high. It wraps from 0xFFFFFFFF to 0.
- R4: A write to the counter loads the written value and wins over a tick in the same cycle. A load is not a tick, so loading a value equal to a match register sets no status.
- R5: When a tick makes the counter equal to match register n and enable bit n is set, status bit n is set at that same clock edge. `irq[n]` equals status bit n and stays high until cleared.
- R6: A tick match on channel n with enable bit n clear sets no status bit and leaves `irq[n]` low.
- R7: Writing the status register (0x14) clears each status bit written as one and keeps each bit written as zero. If a new match sets a bit in the same cycle that bit is cleared, the bit ends up set.
- R8: A tick match on channel 3 while watchdog arm bit 0 is set raises `wdog_rst_req` for exactly one cycle, starting in the cycle after the edge. The same edge clears the arm bit. This does not depend on the interrupt enable.
- R9: An access to any other byte address, including unaligned ones, returns zero on read and changes no register on write. It raises `bus_err` for one cycle, in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_err | output | 1 | Unmapped access flag, one-cycle pulse |
| irq | output | 4 | Per-channel interrupt, mirrors status |
| wdog_rst_req | output | 1 | Watchdog reset request pulse |

## Verification
Two functions can collide in one cycle. The first case is a status clear that lands in the same cycle as a tick creating a new match on the bit being cleared. The bench drives the tick and the status write at the same falling edge and expects the interrupt to remain high afterwards. The second case is a counter load in the same cycle as a tick. The bench reads the counter back and expects the loaded value, not that value plus one.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

    localparam int NUM_CH  = 4;
    localparam int ADDR_W  = 8;
    localparam int WDOG_CH = 3;

    localparam logic [ADDR_W-1:0] OFF_MATCH0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MATCH1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MATCH2 = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MATCH3 = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_WDARM  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_INTEN  = 8'h1C;

    typedef enum logic [3:0] {
        RS_MATCH0, RS_MATCH1, RS_MATCH2, RS_MATCH3,
        RS_COUNT, RS_STATUS, RS_WDARM, RS_INTEN, RS_NONE
    } reg_sel_e;

    typedef struct packed {
        logic wr;
        logic rd;
        reg_sel_e sel;
    } bus_acc_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_MATCH0: return RS_MATCH0;
            OFF_MATCH1: return RS_MATCH1;
            OFF_MATCH2: return RS_MATCH2;
            OFF_MATCH3: return RS_MATCH3;
            OFF_COUNT:  return RS_COUNT;
            OFF_STATUS: return RS_STATUS;
            OFF_WDARM:  return RS_WDARM;
            OFF_INTEN:  return RS_INTEN;
            default:    return RS_NONE;
        endcase
    endfunction

    function automatic reg_sel_e chan_sel(input int idx);
        case (idx)
            0:       return RS_MATCH0;
            1:       return RS_MATCH1;
            2:       return RS_MATCH2;
            default: return RS_MATCH3;
        endcase
    endfunction

endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_inc
);
    assign cnt_inc = cnt_q + W'(1);

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (ld)  cnt_q <= ld_val;
        else if (adv) cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic [W-1:0] cnt_inc,
    output logic [W-1:0] match_q,
    output logic         hit
);
    // Hit when the advancing counter is about to take the match value.
    assign hit = adv && (cnt_inc == match_q);

    always_ff @(posedge clk) begin
        if (rst)     match_q <= '0;
        else if (ld) match_q <= ld_val;
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import match_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]    bus_rdata,
    output logic                bus_err,
    output logic [NUM_CH-1:0]   irq,
    output logic                wdog_rst_req
);
    localparam int PAD_CH = CNT_W - NUM_CH;

    bus_acc_t              acc;
    logic                  cnt_ld, adv;
    logic [CNT_W-1:0]      cnt_q, cnt_inc;
    logic [CNT_W-1:0]      match_q [NUM_CH];
    logic [NUM_CH-1:0]     hit;
    logic [NUM_CH-1:0]     status_q, status_set, status_clr;
    logic [NUM_CH-1:0]     ien_q;
    logic                  wde_q;
    logic                  wd_fire;
    logic [CNT_W-1:0]      rd_mux;
    logic [CNT_W-1:0]      rdata_q;
    logic                  err_q, rst_req_q;

    always_comb begin
        acc.sel = decode_addr(bus_addr);
        acc.wr  = bus_sel && bus_wr;
        acc.rd  = bus_sel && !bus_wr;
    end

    assign cnt_ld = acc.wr && (acc.sel == RS_COUNT);
    assign adv    = tick_en && !cnt_ld;

    mt_counter #(.W(CNT_W)) counter_i (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .ld     (cnt_ld),
        .ld_val (bus_wdata),
        .cnt_q  (cnt_q),
        .cnt_inc(cnt_inc)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic ch_ld;
        assign ch_ld = acc.wr && (acc.sel == chan_sel(g));
        mt_match_chan #(.W(CNT_W)) chan_i (
            .clk    (clk),
            .rst    (rst),
            .ld     (ch_ld),
            .ld_val (bus_wdata),
            .adv    (adv),
            .cnt_inc(cnt_inc),
            .match_q(match_q[g]),
            .hit    (hit[g])
        );
    end

    assign status_set = hit & ien_q;
    assign status_clr = (acc.wr && acc.sel == RS_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;
    assign wd_fire    = hit[WDOG_CH] && wde_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            ien_q     <= '0;
            wde_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            // A fresh match wins over a clear of the same bit.
            status_q  <= (status_q & ~status_clr) | status_set;
            rst_req_q <= wd_fire;
            if (acc.wr && acc.sel == RS_INTEN)
                ien_q <= bus_wdata[NUM_CH-1:0];
            if (wd_fire)
                wde_q <= 1'b0;
            else if (acc.wr && acc.sel == RS_WDARM)
                wde_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (acc.sel)
            RS_MATCH0: rd_mux = match_q[0];
            RS_MATCH1: rd_mux = match_q[1];
            RS_MATCH2: rd_mux = match_q[2];
            RS_MATCH3: rd_mux = match_q[3];
            RS_COUNT:  rd_mux = cnt_q;
            RS_STATUS: rd_mux = {{PAD_CH{1'b0}}, status_q};
            RS_WDARM:  rd_mux = {{(CNT_W-1){1'b0}}, wde_q};
            RS_INTEN:  rd_mux = {{PAD_CH{1'b0}}, ien_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (acc.rd) rdata_q <= rd_mux;
            err_q <= bus_sel && (acc.sel == RS_NONE);
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_err      = err_q;
    assign irq          = status_q;
    assign wdog_rst_req = rst_req_q;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
    import match_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               tick_en,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [CNT_W-1:0]   bus_rdata,
    input logic               bus_err,
    input logic [NUM_CH-1:0]  irq,
    input logic               wdog_rst_req,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [NUM_CH-1:0]  ien_q,
    input logic               wde_q
);
    logic cnt_wr, stat_wr;
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == OFF_COUNT);
    assign stat_wr = bus_sel && bus_wr && (bus_addr == OFF_STATUS);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    assert_irq_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq & ~$past(irq) & ~$past(ien_q)) == '0));

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !stat_wr) |=> $stable(irq));

    assert_wdog_once_R8: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_req |-> (!wde_q && !$past(wdog_rst_req)));

    assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !$past(bus_wr)) |-> (bus_rdata == '0));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .irq         (irq),
    .wdog_rst_req(wdog_rst_req),
    .cnt_q       (cnt_q),
    .ien_q       (ien_q),
    .wde_q       (wde_q)
);

// File: tb/match_timer_tb.sv
module match_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        wdog_rst_req;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    match_timer dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq),
        .wdog_rst_req(wdog_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    initial begin : watchdog
        #400000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic e;
        logic [31:0] base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {28'd0, irq}, 0);
        check("R1 wdog", {31'd0, wdog_rst_req}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(8'(a*4), d, e);
            check("R1 reset read", d, 0);
            check("R1 no err", {31'd0, e}, 0);
        end
        // R2 readback
        for (int c = 0; c < 4; c++) begin
            wr(8'(c*4), 32'hA5A5_0000 + 32'(c * 32'h1111));
            rd(8'(c*4), d, e);
            check("R2 match readback", d, 32'hA5A5_0000 + 32'(c * 32'h1111));
        end
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d, e); check("R2 inten bits", d, 32'hF);
        wr(8'h18, 32'hFFFF_FFFE); rd(8'h18, d, e); check("R2 wdarm bits", d, 0);
        wr(8'h18, 32'h3);         rd(8'h18, d, e); check("R2 wdarm bit0", d, 1);
        wr(8'h18, 0); wr(8'h1C, 0);
        // R3 counting and wrap
        wr(8'h10, 10); tick(7); rd(8'h10, d, e); check("R3 count", d, 17);
        wr(8'h10, 32'hFFFF_FFFE); tick(3); rd(8'h10, d, e); check("R3 wrap", d, 1);
        // R4 load wins over tick
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 500;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(8'h10, d, e); check("R4 load over tick", d, 500);
        wr(8'h00, 600); wr(8'h1C, 1); wr(8'h10, 600);
        check("R4 load no match", {28'd0, irq}, 0);
        wr(8'h1C, 0);
        // R5/R6 sweep over channel and enable
        for (int c = 0; c < 4; c++) begin
            for (int en = 0; en < 2; en++) begin
                base = 32'(1000 * (c + 1) + 100 * en);
                wr(8'h14, 32'hF);
                wr(8'h1C, 32'(en) << c);
                wr(8'(c*4), base + 5);
                wr(8'h10, base);
                tick(4);
                check(en ? "R5 before match" : "R6 before match", {28'd0, irq}, 0);
                tick(1);
                check(en ? "R5 on match" : "R6 disabled", {28'd0, irq}, 32'(en) << c);
                tick(2);
                rd(8'h14, d, e);
                check(en ? "R5 sticky status" : "R6 no status", d, 32'(en) << c);
            end
        end
        // R7 W1C
        wr(8'h1C, 32'hF);
        for (int c = 0; c < 4; c++) wr(8'(c*4), 32'(3000 + c));
        wr(8'h10, 2999); tick(4);
        check("R7 all set", {28'd0, irq}, 32'hF);
        wr(8'h14, 32'h5); check("R7 partial clear", {28'd0, irq}, 32'hA);
        wr(8'h14, 32'h0); check("R7 zero write", {28'd0, irq}, 32'hA);
        wr(8'h14, 32'hF); check("R7 full clear", {28'd0, irq}, 0);
        // R7 set wins over same-cycle clear
        wr(8'h04, 100); wr(8'h10, 99);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h2;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        check("R7 set wins", {28'd0, irq}, 32'h2);
        wr(8'h14, 32'hF); wr(8'h1C, 0);
        // R8 watchdog
        wr(8'h0C, 2000); wr(8'h18, 1); wr(8'h10, 1999);
        check("R8 quiet before", {31'd0, wdog_rst_req}, 0);
        tick(1);
        check("R8 pulse", {31'd0, wdog_rst_req}, 1);
        check("R8 no irq", {28'd0, irq}, 0);
        @(negedge clk);
        check("R8 one cycle", {31'd0, wdog_rst_req}, 0);
        rd(8'h18, d, e); check("R8 disarmed", d, 0);
        wr(8'h10, 1999); tick(1);
        check("R8 no second pulse", {31'd0, wdog_rst_req}, 0);
        // R9 unmapped
        rd(8'h20, d, e); check("R9 read zero", d, 0); check("R9 err", {31'd0, e}, 1);
        @(negedge clk); check("R9 err one cycle", {31'd0, bus_err}, 0);
        wr(8'h00, 32'h1234_5678);
        wr(8'h01, 32'hDEAD_BEEF); check("R9 wr err", {31'd0, bus_err}, 1);
        wr(8'h40, 32'hDEAD_BEEF);
        rd(8'h00, d, e); check("R9 write ignored", d, 32'h1234_5678);
        rd(8'h02, d, e); check("R9 unaligned read", d, 0); check("R9 unaligned err", {31'd0, e}, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule